// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This synchronous controller drives the reset line of a microprocessor. It watches a digitized supply-good flag, which is high while the supply sits above the reset threshold, together with a watchdog input that the software must keep toggling and a flag that shows the watchdog input is left floating.

The block asserts reset in three cases:
- **Supply loss.** Reset asserts while the supply is low.
- **Supply return.** When the supply comes back, reset stays asserted for a fixed stretch, nominally 200 ms.
- **Watchdog time-out.** Reset asserts when the watchdog input shows no transition for a full interval, nominally 1.6 s.

After a watchdog pulse ends, a fresh interval begins. A stuck input therefore produces a reset pulse every interval plus pulse width. While the float flag is set, supervision is suspended.

All durations are given in milliseconds and converted to clock cycles from the clock frequency parameter. A parameter also selects whether the reset output is active-low or active-high.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it, the reset output is at its asserted level.
- R2: When `supply_ok` is sampled high at edge k while the supply is low or just restored, reset stays asserted through edge k+P-1 and is released after edge k+P. P is `CLK_HZ/1000*PULSE_MS` cycles.
- R3: `supply_ok` sampled low at an edge asserts reset after that edge. Reset then stays asserted as long as `supply_ok` stays low.
- R4: A `supply_ok` drop during an active reset stretch cancels the stretch. A full P-cycle stretch restarts once the supply returns.
- R5: If the synchronized watchdog input shows no transition for W cycles after reset is released, a P-cycle reset pulse starts. W is `CLK_HZ/1000*WDOG_MS` cycles.
- R6: Both rising and falling transitions of `wdog_in` count as service and restart the W-cycle interval. Regular toggling therefore never causes a reset.
- R7: With `wdog_in` stuck, reset pulses repeat with a period of W+P cycles: P cycles asserted, then W cycles released.
- R8: While `wdog_float` is high, no watchdog time-out occurs. After `wdog_float` falls, the interval starts from zero.
- R9: The watchdog counter is held at zero while reset is asserted. Input activity during reset is ignored, and the interval starts at release.
- R10: With `ACTIVE_HIGH=0` the output is low when asserted. With `ACTIVE_HIGH=1` the output is high when asserted.
- R11: `wdog_in` and `wdog_float` each pass through a two-flop synchronizer before use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above threshold, synchronous to `clk` |
| wdog_in | input | 1 | Watchdog service input, asynchronous |
| wdog_float | input | 1 | Watchdog input is floating, asynchronous |
| rst_out | output | 1 | Reset to the processor, polarity set by `ACTIVE_HIGH` |

## Verification
The checks assume that `supply_ok` is already synchronous to `clk`, so the bench changes it only on falling clock edges. The checks also assume that `wdog_in` and `wdog_float` can be asynchronous but hold each level for at least two cycles, so the synchronizer never drops a transition. The stimulus toggles the watchdog input at intervals of ten cycles or more. It holds every flag change for several cycles, and it uses scaled durations (P=20, W=50) so that repeated pulses, brown-outs inside a stretch and float windows all fit into a short run.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic flt;
        logic wdi;
    } wd_in_s;

    function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned ms);
        return (clk_hz / 1000) * ms;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sup_pulse_gen.sv
module sup_pulse_gen
    import sup_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       wdog_expire,
    output logic       reset_active,
    output sup_state_e state_o
);
    localparam int unsigned PW = cnt_width(PULSE_CYC);
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

    sup_state_e    state;
    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    if (supply_ok) begin
                        state <= ST_STRETCH;
                        cnt   <= '0;
                    end
                end
                ST_STRETCH: begin
                    if (!supply_ok) begin
                        state <= ST_HOLD;
                    end else if (cnt == LAST) begin
                        state <= ST_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!supply_ok) begin
                        state <= ST_HOLD;
                    end else if (wdog_expire) begin
                        state <= ST_STRETCH;
                        cnt   <= '0;
                    end
                end
                default: state <= ST_HOLD;
            endcase
        end
    end

    assign reset_active = (state != ST_RUN);
    assign state_o      = state;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int unsigned WDOG_CYC = 50,
    parameter int unsigned WCW      = cnt_width(WDOG_CYC)
) (
    input  logic           clk,
    input  logic           rst,
    input  wd_in_s         wd_s,
    input  logic           reset_active,
    output logic           wdog_expire,
    output logic [WCW-1:0] wcnt
);
    localparam logic [WCW-1:0] LAST = WCW'(WDOG_CYC - 1);

    logic wdi_prev;
    logic serviced;
    logic run_en;

    assign serviced    = wd_s.wdi ^ wdi_prev;
    assign run_en      = !reset_active && !wd_s.flt && !serviced;
    assign wdog_expire = run_en && (wcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wdi_prev <= 1'b0;
            wcnt     <= '0;
        end else begin
            wdi_prev <= wd_s.wdi;
            if (!run_en || wdog_expire) begin
                wcnt <= '0;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned PULSE_MS    = 200,
    parameter int unsigned WDOG_MS     = 1600,
    parameter bit          ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wdog_in,
    input  logic wdog_float,
    output logic rst_out
);
    localparam int unsigned PULSE_CYC = ms_to_cycles(CLK_HZ, PULSE_MS);
    localparam int unsigned WDOG_CYC  = ms_to_cycles(CLK_HZ, WDOG_MS);
    localparam int unsigned WCW       = cnt_width(WDOG_CYC);

    wd_in_s         wd_raw;
    wd_in_s         wd_s;
    logic           reset_active;
    logic           wdog_expire;
    logic [WCW-1:0] wcnt;
    sup_state_e     state;

    assign wd_raw.wdi = wdog_in;
    assign wd_raw.flt = wdog_float;

    // R11: two-flop synchronizer on the asynchronous watchdog pins
    sup_sync #(.WIDTH($bits(wd_in_s))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (wd_raw),
        .q   (wd_s)
    );

    sup_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk          (clk),
        .rst          (rst),
        .supply_ok    (supply_ok),
        .wdog_expire  (wdog_expire),
        .reset_active (reset_active),
        .state_o      (state)
    );

    sup_wdog #(.WDOG_CYC(WDOG_CYC), .WCW(WCW)) u_wdog (
        .clk          (clk),
        .rst          (rst),
        .wd_s         (wd_s),
        .reset_active (reset_active),
        .wdog_expire  (wdog_expire),
        .wcnt         (wcnt)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pos
            assign rst_out = reset_active;
        end else begin : g_neg
            assign rst_out = !reset_active;
        end
    endgenerate
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk
    import sup_pkg::*;
#(
    parameter bit          ACTIVE_HIGH = 1'b0,
    parameter int unsigned WCW         = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           supply_ok,
    input logic           rst_out,
    input logic           reset_active,
    input logic           wdog_expire,
    input logic           flt_s,
    input logic [WCW-1:0] wcnt,
    input sup_state_e     state
);
    assert_reset_level_R1_R10: assert property (@(posedge clk)
        rst |=> (rst_out == ACTIVE_HIGH));

    assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_active) |-> $past(supply_ok));

    assert_supply_low_asserts_R3: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (reset_active && state == ST_HOLD));

    assert_expire_starts_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (wdog_expire && supply_ok) |=> (state == ST_STRETCH));

    assert_float_clears_R8: assert property (@(posedge clk) disable iff (rst)
        flt_s |=> (wcnt == '0));

    assert_wdog_held_R9: assert property (@(posedge clk) disable iff (rst)
        reset_active |=> (wcnt == '0));

    assert_no_expire_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        wdog_expire |-> !reset_active);
endmodule

bind sup_reset_ctrl sup_reset_chk #(.ACTIVE_HIGH(ACTIVE_HIGH), .WCW(WCW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .rst_out      (rst_out),
    .reset_active (reset_active),
    .wdog_expire  (wdog_expire),
    .flt_s        (wd_s.flt),
    .wcnt         (wcnt),
    .state        (state)
);

// File: tb/sim_sup_reset_ctrl.sv
`timescale 1ns/1ps
module sim_sup_reset_ctrl;
    localparam int P = 20;
    localparam int W = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0;
    logic wdog_in = 1'b0;
    logic wdog_float = 1'b0;
    logic rst_n_out;
    logic rst_p_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sup_reset_ctrl #(.CLK_HZ(1000), .PULSE_MS(P), .WDOG_MS(W), .ACTIVE_HIGH(1'b0)) u0 (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .wdog_in(wdog_in),
        .wdog_float(wdog_float), .rst_out(rst_n_out));

    sup_reset_ctrl #(.CLK_HZ(1000), .PULSE_MS(P), .WDOG_MS(W), .ACTIVE_HIGH(1'b1)) u1 (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .wdog_in(wdog_in),
        .wdog_float(wdog_float), .rst_out(rst_p_out));

    // behavioural reference: 0 hold, 1 stretch, 2 running
    int    m_state = 0;
    int    m_pc = 0;
    int    m_wc = 0;
    bit    m_q[$] = '{0, 0, 0};
    bit    m_fq[$] = '{0, 0};
    bit    m_dropped = 0;
    bit    m_wd_repeat = 0;
    bit    m_serviced = 0;
    string m_tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_pc = 0; m_wc = 0;
            m_q = '{0, 0, 0}; m_fq = '{0, 0};
            m_dropped = 0; m_wd_repeat = 0; m_serviced = 0;
            m_tag = "R1";
        end else begin
            bit ed, fl, act, exp_t;
            ed = m_q[1] ^ m_q[2];
            fl = m_fq[1];
            act = (m_state != 2);
            exp_t = !act && !fl && !ed && (m_wc == W - 1);
            if (act || fl || ed || exp_t) m_wc = 0; else m_wc++;
            if (!act && (ed || fl)) begin m_serviced = 1; m_wd_repeat = 0; end
            case (m_state)
                0: if (supply_ok) begin
                        m_state = 1; m_pc = 0;
                        m_tag = m_dropped ? "R4" : "R2";
                    end else m_tag = "R3";
                1: if (!supply_ok) begin
                        m_state = 0; m_dropped = 1; m_tag = "R3";
                    end else if (m_pc == P - 1) begin
                        m_state = 2; m_dropped = 0; m_serviced = 0;
                    end else m_pc++;
                default: if (!supply_ok) begin
                        m_state = 0; m_tag = "R3"; m_wd_repeat = 0;
                    end else if (exp_t) begin
                        m_state = 1; m_pc = 0;
                        m_tag = m_wd_repeat ? "R7" : "R5";
                        m_wd_repeat = 1;
                    end
            endcase
            if (m_state == 2) m_tag = fl ? "R8" : (m_serviced ? "R6" : "R9");
            void'(m_q.pop_back()); m_q.push_front(wdog_in);
            void'(m_fq.pop_back()); m_fq.push_front(wdog_float);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare both polarities with the model on every cycle, away from the edge
    int pulses_n = 0;
    logic prev_n = 1'b0;
    always @(negedge clk) begin
        if (!done) begin
            bit exp_act;
            exp_act = rst ? 1'b1 : (m_state != 2);
            check(m_tag, rst_n_out, !exp_act);
            check("R10", rst_p_out, exp_act);
            if (prev_n && !rst_n_out) pulses_n++;
            prev_n = rst_n_out;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_for(input int n, input int gap);
        for (int i = 0; i < n; i += gap) begin
            step(gap);
            wdog_in = ~wdog_in;
        end
    endtask

    initial begin
        int base;
        step(3);
        check("R1", rst_n_out, 0);
        check("R1", rst_p_out, 1);
        rst = 1'b0;
        step(6);                        // R3: supply still low
        check("R3", rst_n_out, 0);
        supply_ok = 1'b1;               // R2 with R9: toggling during the stretch
        toggle_for(P + 10, 10);
        toggle_for(200, 10);            // R6: regular service
        base = pulses_n;
        step(3 * (W + P) + 5);          // R5, R7: stuck input
        check("R7", pulses_n - base, 3);
        base = pulses_n;
        wdog_float = 1'b1;              // R8
        step(200);
        check("R8", pulses_n - base, 0);
        wdog_float = 1'b0;
        step(W + P + 10);
        supply_ok = 1'b0;               // R3 brown-out
        step(10);
        check("R3", rst_n_out, 0);
        supply_ok = 1'b1;
        step(8);
        supply_ok = 1'b0;               // R4: drop inside the stretch
        step(3);
        supply_ok = 1'b1;
        toggle_for(P + 40, 12);
        check("R4", rst_n_out, 1);
        step(5);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule